// File: doc/BRIEF.md
# Programmable Chip Select Controller

The block compares the address of every bus cycle with a bank of programmable select channels and drives one active-low select line per channel toward memory and peripherals. Each channel holds a base address, a mask of address bits left out of the compare, a port width, a burst-capable flag, a wait-state count and a choice between internal and external termination. With internal termination the block counts the wait states itself and returns a one-cycle transfer acknowledge; with external termination it passes through the acknowledge of the addressed device.

Channel 0 serves as the boot select: out of reset it answers every normal address, and its port width and termination come from three strap inputs. Once software writes its control word it decodes only its own base and mask, so the boot memory can be relocated. Channel 1 may be set to answer CPU-space cycles, interrupt acknowledges among them. Software programs the channels through a write-only register port addressed by channel and field.

Top module: `csel_ctrl`

## Requirements
- R1: All select outputs are active low; after reset and whenever no cycle is in progress every bit of `cs_n_o` is 1 and `ta_o` is 0.
- R2: Out of reset channel 0 matches any normal (non CPU-space) address; its select asserts in the cycle after the clock edge that sees `as_i` rise.
- R3: In the first clock after reset, channel 0 takes its width from `strap_i[1:0]` and its termination from `strap_i[2]` (1 = external); its reset wait count is 15.
- R4: The first write to channel 0's control field ends global mode; afterwards channel 0 matches only through its valid bit, base and mask.
- R5: A channel matches when `(addr_i ^ base) & ~mask` is zero; mask bits set to 1 are excluded from the compare.
- R6: Every channel other than 0 is disabled after reset and matches nothing until its valid bit (control bit 0) is written as 1.
- R7: When several channels match, only the lowest-numbered one asserts; at most one select is low at any time.
- R8: With internal termination (control bit 8 = 0) and wait count W (control bits 7:4), the select stays low for W+1 cycles and `ta_o` is high in the last of them only.
- R9: With external termination (control bit 8 = 1) the cycle lasts until `ext_ta_i` is high; `ta_o` follows `ext_ta_i` while the select is low.
- R10: Control bits 2:1 give the width reported on `width_o` during the cycle: 00 = 32-bit, 01 = 8-bit, 10 = 16-bit, 11 reserved and reported as 00; `burst_o` reports control bit 3.
- R11: During a CPU-space cycle (`cpu_space_i` = 1) only channel 1 can assert, and only with control bit 9 set, regardless of address; control bit 9 has no effect on other channels.
- R12: Every select deasserts in the cycle after the one in which `ta_o` is high; a rise of `as_i` that matches no channel produces no select and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 3 | Boot channel width [1:0] and external termination [2] |
| reg_we_i | input | 1 | Register write strobe |
| reg_ch_i | input | CH_W | Channel written |
| reg_field_i | input | 2 | Field: 0 base, 1 mask, 2 control |
| reg_wdata_i | input | ADDR_W | Write data |
| as_i | input | 1 | Address strobe, held high until the acknowledge |
| addr_i | input | ADDR_W | Cycle address |
| cpu_space_i | input | 1 | Cycle is a CPU-space access |
| ext_ta_i | input | 1 | External acknowledge |
| cs_n_o | output | NUM_CH | Active-low selects |
| ta_o | output | 1 | Transfer acknowledge |
| width_o | output | 2 | Port width of the active channel |
| burst_o | output | 1 | Burst-capable flag of the active channel |

## Verification
The assertions take for granted that the bus master keeps `as_i` high and the address and space type stable from the rising strobe until it sees `ta_o`, and that it lowers `as_i` within a cycle after the acknowledge; the select-implies-strobe property relies on it. Straps are held steady through reset release. The bench drives every cycle through one task that raises the strobe at a falling edge, keeps all bus inputs frozen, and drops the strobe right after observing the acknowledge, while register writes happen only between cycles. Random addresses are drawn either inside a programmed window with random masked bits or fully at random, so matching, overlapping and missing cycles all occur.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int WS_W = 4;

  typedef enum logic [1:0] {
    F_BASE = 2'd0,
    F_MASK = 2'd1,
    F_CTRL = 2'd2
  } field_e;

  typedef enum logic [1:0] {
    PW_32  = 2'd0,
    PW_8   = 2'd1,
    PW_16  = 2'd2,
    PW_RSV = 2'd3
  } pw_e;

  typedef struct packed {
    logic            valid;
    logic [1:0]      width;
    logic            burst;
    logic [WS_W-1:0] ws;
    logic            ext;
    logic            cpu;
  } ctrl_t;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        strap_i,
  input  logic              we_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [1:0]        field_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base_o [NUM_CH],
  output logic [ADDR_W-1:0] mask_o [NUM_CH],
  output ctrl_t             ctrl_o [NUM_CH],
  output logic              glob_o
);
  logic strap_pend_q;
  logic glob_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_pend_q <= 1'b1;
      glob_q       <= 1'b1;
    end else begin
      strap_pend_q <= 1'b0;
      if (we_i && ch_i == '0 && field_i == F_CTRL) glob_q <= 1'b0;
    end
  end

  assign glob_o = glob_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic  hit_w;
    ctrl_t wr_ctrl;

    assign hit_w = we_i && (ch_i == CH_W'(i));

    always_comb begin
      wr_ctrl       = '0;
      wr_ctrl.valid = wdata_i[0];
      wr_ctrl.width = wdata_i[2:1];
      wr_ctrl.burst = wdata_i[3];
      wr_ctrl.ws    = wdata_i[4 +: WS_W];
      wr_ctrl.ext   = wdata_i[8];
      wr_ctrl.cpu   = (i == 1) ? wdata_i[9] : 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[i] <= '0;
        mask_o[i] <= '0;
        ctrl_o[i] <= '0;
        if (i == 0) ctrl_o[i].ws <= '1;
      end else begin
        if (i == 0 && strap_pend_q) begin
          ctrl_o[i].width <= strap_i[1:0];
          ctrl_o[i].ext   <= strap_i[2];
        end
        if (hit_w) begin
          case (field_i)
            F_BASE:  base_o[i] <= wdata_i;
            F_MASK:  mask_o[i] <= wdata_i;
            F_CTRL:  ctrl_o[i] <= wr_ctrl;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_space_i,
  input  logic [ADDR_W-1:0] base_i [NUM_CH],
  input  logic [ADDR_W-1:0] mask_i [NUM_CH],
  input  ctrl_t             ctrl_i [NUM_CH],
  input  logic              glob_i,
  output logic [NUM_CH-1:0] hit_o,
  output logic              any_o,
  output ctrl_t             sel_o
);
  logic [NUM_CH-1:0] raw;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    logic addr_eq;
    assign addr_eq = ((addr_i ^ base_i[i]) & ~mask_i[i]) == '0;
    if (i == 1) begin : g_cpu
      assign raw[i] = cpu_space_i ? (ctrl_i[i].valid && ctrl_i[i].cpu)
                                  : (ctrl_i[i].valid && addr_eq);
    end else if (i == 0) begin : g_boot
      assign raw[i] = !cpu_space_i && (glob_i || (ctrl_i[i].valid && addr_eq));
    end else begin : g_plain
      assign raw[i] = !cpu_space_i && ctrl_i[i].valid && addr_eq;
    end
  end

  // fixed priority: lowest index wins
  always_comb begin
    hit_o = '0;
    sel_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (raw[i]) begin
        hit_o    = '0;
        hit_o[i] = 1'b1;
        sel_o    = ctrl_i[i];
      end
    end
  end

  assign any_o = |raw;
endmodule

// File: rtl/csel_timer.sv
module csel_timer
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_i,
  input  logic              ext_ta_i,
  input  logic              any_i,
  input  logic [NUM_CH-1:0] hit_i,
  input  ctrl_t             sel_i,
  output logic [NUM_CH-1:0] cs_n_o,
  output logic              ta_o,
  output logic [1:0]        width_o,
  output logic              burst_o
);
  logic              as_q;
  logic              busy_q;
  logic [NUM_CH-1:0] hit_q;
  logic [WS_W-1:0]   cnt_q;
  logic              ext_q;
  logic              start;

  assign start = as_i && !as_q && any_i && !busy_q;
  assign ta_o  = busy_q && (ext_q ? ext_ta_i : (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q    <= 1'b0;
      busy_q  <= 1'b0;
      hit_q   <= '0;
      cnt_q   <= '0;
      ext_q   <= 1'b0;
      width_o <= PW_32;
      burst_o <= 1'b0;
    end else begin
      as_q <= as_i;
      if (start) begin
        busy_q  <= 1'b1;
        hit_q   <= hit_i;
        cnt_q   <= sel_i.ws;
        ext_q   <= sel_i.ext;
        width_o <= (sel_i.width == PW_RSV) ? PW_32 : sel_i.width;
        burst_o <= sel_i.burst;
      end else if (busy_q) begin
        if (ta_o) begin
          busy_q <= 1'b0;
          hit_q  <= '0;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cs_n_o = ~hit_q;
endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
  import csel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        strap_i,
  input  logic              reg_we_i,
  input  logic [CH_W-1:0]   reg_ch_i,
  input  logic [1:0]        reg_field_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              as_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_space_i,
  input  logic              ext_ta_i,
  output logic [NUM_CH-1:0] cs_n_o,
  output logic              ta_o,
  output logic [1:0]        width_o,
  output logic              burst_o
);
  logic [ADDR_W-1:0] base [NUM_CH];
  logic [ADDR_W-1:0] mask [NUM_CH];
  ctrl_t             ctrl [NUM_CH];
  logic              glob;
  logic [NUM_CH-1:0] hit;
  logic              any;
  ctrl_t             sel;

  csel_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_i),
    .we_i    (reg_we_i),
    .ch_i    (reg_ch_i),
    .field_i (reg_field_i),
    .wdata_i (reg_wdata_i),
    .base_o  (base),
    .mask_o  (mask),
    .ctrl_o  (ctrl),
    .glob_o  (glob)
  );

  csel_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr_i      (addr_i),
    .cpu_space_i (cpu_space_i),
    .base_i      (base),
    .mask_i      (mask),
    .ctrl_i      (ctrl),
    .glob_i      (glob),
    .hit_o       (hit),
    .any_o       (any),
    .sel_o       (sel)
  );

  csel_timer #(.NUM_CH(NUM_CH)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .as_i     (as_i),
    .ext_ta_i (ext_ta_i),
    .any_i    (any),
    .hit_i    (hit),
    .sel_i    (sel),
    .cs_n_o   (cs_n_o),
    .ta_o     (ta_o),
    .width_o  (width_o),
    .burst_o  (burst_o)
  );
endmodule

// File: rtl/csel_ctrl_chk.sv
module csel_ctrl_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              as_i,
  input logic [NUM_CH-1:0] cs_n_o,
  input logic              ta_o
);
  // R7: never more than one select low
  a_r7_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  // R12: acknowledge ends the cycle
  a_r12_release_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> (&cs_n_o));

  // R1: acknowledge only inside a selected cycle
  a_r1_ack_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> !(&cs_n_o));

  // R2: a select is only low while the strobe is held
  a_r2_select_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&cs_n_o) |-> as_i);

  // R8: select pattern is held until the acknowledge
  a_r8_select_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&cs_n_o) && !ta_o) |=> $stable(cs_n_o));

  // R12: the acknowledge is a single pulse under internal timing or a dropped strobe
  a_r12_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> !ta_o);
endmodule

bind csel_ctrl csel_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .as_i   (as_i),
  .cs_n_o (cs_n_o),
  .ta_o   (ta_o)
);

// File: tb/sim_csel_ctrl.sv
`timescale 1ns/1ps
module sim_csel_ctrl;
  localparam int N  = 4;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    strap_i = 3'b110;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_ch_i = '0;
  logic [1:0]    reg_field_i = '0;
  logic [AW-1:0] reg_wdata_i = '0;
  logic          as_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          cpu_space_i = 1'b0;
  logic          ext_ta_i = 1'b0;
  logic [N-1:0]  cs_n_o;
  logic          ta_o;
  logic [1:0]    width_o;
  logic          burst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [AW-1:0] m_base [N];
  logic [AW-1:0] m_mask [N];
  logic [9:0]    m_ctrl [N];
  bit            m_glob;

  always #10 clk_i = ~clk_i;

  csel_ctrl #(.NUM_CH(N), .ADDR_W(AW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int fld, input logic [AW-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_ch_i = 2'(ch); reg_field_i = 2'(fld); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (fld == 0) m_base[ch] = d;
    else if (fld == 1) m_mask[ch] = d;
    else begin
      m_ctrl[ch] = d[9:0];
      if (ch != 1) m_ctrl[ch][9] = 1'b0;
      if (ch == 0) m_glob = 0;
    end
  endtask

  function automatic int exp_hit(input logic [AW-1:0] a, input bit cpu);
    for (int i = 0; i < N; i++) begin
      if (cpu) begin
        if (i == 1 && m_ctrl[1][0] && m_ctrl[1][9]) return 1;
      end else begin
        if (i == 0 && m_glob) return 0;
        if (m_ctrl[i][0] && (((a ^ m_base[i]) & ~m_mask[i]) == '0)) return i;
      end
    end
    return -1;
  endfunction

  function automatic logic [1:0] exp_width(input logic [1:0] w);
    return (w == 2'b11) ? 2'b00 : w;
  endfunction

  // one bus cycle; ext_dly = cycle index at which the device acknowledges
  task automatic bus(input logic [AW-1:0] a, input bit cpu, input int ext_dly, input string tag);
    int h = exp_hit(a, cpu);
    int n = 0;
    int ack_at;
    bit seen = 0;
    @(negedge clk_i);
    as_i = 1'b1; addr_i = a; cpu_space_i = cpu;
    if (h < 0) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk_i); #1;
        chk(&cs_n_o && !ta_o, {tag, " R12 no match"}, {ta_o, cs_n_o}, {1'b0, 4'hf});
      end
    end else begin
      ack_at = m_ctrl[h][8] ? ext_dly : int'(m_ctrl[h][7:4]) + 1;
      while (!seen && n < 40) begin
        @(negedge clk_i);
        n++;
        ext_ta_i = m_ctrl[h][8] && (n >= ext_dly);
        #1;
        chk(cs_n_o == ~(N'(1) << h), {tag, " R7 select"}, cs_n_o, ~(N'(1) << h));
        if (ta_o) seen = 1;
      end
      chk(n == ack_at, {tag, m_ctrl[h][8] ? " R9 ext ack" : " R8 wait ack"}, n, ack_at);
      chk(width_o == exp_width(m_ctrl[h][2:1]) && burst_o == m_ctrl[h][3],
          {tag, " R10 width"}, {burst_o, width_o}, {m_ctrl[h][3], exp_width(m_ctrl[h][2:1])});
      @(negedge clk_i); #1;
      chk(&cs_n_o && !ta_o, {tag, " R12 release"}, {ta_o, cs_n_o}, {1'b0, 4'hf});
    end
    as_i = 1'b0; ext_ta_i = 1'b0; cpu_space_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_ctrl[i] = '0;
    end
    m_ctrl[0] = {1'b0, strap_i[2], 4'hf, 1'b0, strap_i[1:0], 1'b0};
    m_glob = 1;
    repeat (3) @(negedge clk_i);
    #1;
    chk(&cs_n_o && !ta_o, "R1 reset idle", {ta_o, cs_n_o}, {1'b0, 4'hf});
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1;
    chk(&cs_n_o && !ta_o, "R1 idle after reset", {ta_o, cs_n_o}, {1'b0, 4'hf});

    // R2 R3: global boot select, straps give 16-bit, external termination
    bus(32'hdead_beef, 0, 3, "R2 R3 boot ext");
    bus(32'h0000_0004, 0, 1, "R2 boot low");
    // R6: enable ch2 only by base write, still disabled
    wr(2, 0, 32'h4000_0000);
    bus(32'h4000_0000, 0, 2, "R6 global still");
    // R11: cpu space with nothing enabled -> no select
    bus(32'h0, 1, 1, "R11 cpu off");
    // R4: program ch0 internal, 2 waits, window 0x0000_xxxx
    wr(0, 1, 32'h0000_ffff);
    wr(0, 2, 32'h0000_0021 | 32'h8);
    bus(32'h0000_1234, 0, 1, "R4 boot relocated");
    bus(32'h1000_0000, 0, 1, "R4 out of window");
    // R5 R10: ch1 8-bit, 0 waits, mask bits 7:0
    wr(1, 0, 32'h2000_0000);
    wr(1, 1, 32'h0000_00ff);
    wr(1, 2, 32'h0000_0003);
    bus(32'h2000_00a5, 0, 1, "R5 masked hit");
    bus(32'h2000_0100, 0, 1, "R5 unmasked miss");
    // R11: ch1 cpu space; ch2 bit9 ignored
    wr(1, 2, 32'h0000_0213);
    bus(32'h7777_0000, 1, 1, "R11 cpu ch1");
    wr(2, 2, 32'h0000_02f7);
    bus(32'h4000_0000, 0, 1, "R10 reserved width");
    wr(1, 2, 32'h0000_0013);
    bus(32'h0, 1, 1, "R11 cpu bit9 clear");
    // R7: overlap ch2/ch3, ch2 wins
    wr(3, 0, 32'h4000_0000);
    wr(3, 2, 32'h0000_0105);
    bus(32'h4000_0000, 0, 1, "R7 overlap");
    wr(2, 2, 32'h0);
    bus(32'h4000_0000, 0, 4, "R9 ch3 ext");

    // random phase
    void'($urandom(32'd1234));
    for (int t = 0; t < 60; t++) begin
      int c = $urandom_range(N - 1, 1);
      logic [AW-1:0] a;
      if (t % 8 == 0) begin
        wr(c, 0, {4'(c), 28'h0});
        wr(c, 1, 32'(($urandom & 32'h0fff_ffff) | 32'hff));
        wr(c, 2, 32'($urandom & 32'h3ff) | 32'h1);
      end
      if ($urandom_range(3, 0) == 0) a = $urandom;
      else a = {4'($urandom_range(N - 1, 0)), 28'($urandom)};
      bus(a, ($urandom_range(7, 0) == 0), $urandom_range(5, 1), "rand R5 R8");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule